// File: doc/BRIEF.md
# Chained Copy Channel Register Unit

This block is the control and status front end of one copy channel that works through a linked list of descriptors held in memory. Software programs the address of the first descriptor and then sets the enable bit. From then on a sequencer fetches each descriptor word by word over a simple memory read port. It hands the transfer to a data-mover stub that takes a fixed number of cycles, then follows the link word to the next descriptor. A link of zero ends the chain. Software watches progress through a busy bit, sticky completion and error flags, and read-back of the descriptor currently in hand. It also gets an optional interrupt pulse for each completed descriptor.

A finished chain can be extended without a restart. Software patches the link word of the last descriptor in memory and then writes the append command. The channel reads that one link word again and, if it is now nonzero, carries on from there. The mover stub is stood in for by a counter. A test input can make the current transfer end with one of four error kinds.

Register offsets: control 0x00, status 0x04, current descriptor 0x0C, next descriptor 0x10, byte count 0x20, descriptor control 0x24. Unmapped offsets read zero. The descriptor read request is a valid/ready handshake. The channel holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is sampled high. It keeps at most one request outstanding and issues no new request until the response arrives. A response is a one-cycle `mem_rsp_valid` pulse that the channel always accepts, so there is no back-pressure on the response side.

Top module: `chdma_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no descriptor request is issued.
- R2: The next-descriptor register is writable while the channel is idle, and writes to it while busy are ignored. A control write that sets enable (bit 0) from 0 while idle, with a nonzero next-descriptor value, starts fetching at that address. The current-descriptor register holds the address of the descriptor being processed.
- R3: Status bit 10 reads 1 from the clock edge that starts the channel until the channel stops.
- R4: Each descriptor is five 32-bit words fetched in order at base+0, +4, +8, +12 and +16. Word 0 is the link, word 3 the byte count (its low 25 bits, up to 16 MiB, read back at 0x20) and word 4 the control word (read back at 0x24). The request handshake obeys the valid/ready rules above.
- R5: Every clean descriptor completion sets end-of-transfer (status bit 9). A nonzero link is followed, and the next-descriptor register takes the link value. A zero link stops the channel and sets end-of-chain (status bit 8).
- R6: A descriptor whose control word has bit 4 set raises `irq` for exactly one cycle on completion, together with end-of-transfer.
- R7: Status bits 9, 8, 5, 3, 2 and 1 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: Writing control bits 1 and 0 together while idle re-reads word 0 of the current descriptor. A nonzero link continues the chain at that address. A zero link returns to idle with flags and current descriptor unchanged.
- R9: With `err_inject` high when a transfer ends, error kind 0, 1, 2 and 3 sets status bit 1, 2, 3 and 5 respectively. The channel then stops without end-of-transfer, without `irq` and without following the link.
- R10: Clearing enable lets the descriptor in progress complete with end-of-transfer. The link is then not followed and end-of-chain is not set.
- R11: Control bit 0 reads back the enable state, and control bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Descriptor word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data |
| err_inject | input | 1 | Makes the transfer ending this cycle fail |
| err_kind | input | 2 | Error kind for an injected failure |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A register write lands at the clock edge that samples it, so status, current descriptor and read-back are valid on the read issued at the following falling edge. The bench therefore writes on one falling edge and reads on a later one. The first descriptor request appears in the cycle after the starting write. End-of-transfer, end-of-chain, error flags and the `irq` pulse all change on the same edge that ends a transfer. For this reason the bench polls the busy bit until it drops, then reads every result, while a falling-edge monitor counts `irq` pulses and logs every accepted request address for comparison against the computed fetch order.

// File: rtl/chdma_pkg.sv
package chdma_pkg;
  localparam int DW     = 32;
  localparam int AW     = 32;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
  localparam logic [REG_AW-1:0] OFS_CUR  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_NEXT = 6'h10;
  localparam logic [REG_AW-1:0] OFS_BCNT = 6'h20;
  localparam logic [REG_AW-1:0] OFS_DCTL = 6'h24;

  localparam int BIT_BUSY = 10;
  localparam int BIT_EOT  = 9;
  localparam int BIT_EOC  = 8;

  // error kind k sets status bit ERR_POS[k]
  localparam int NUM_ERR = 4;
  localparam int KIND_W  = $clog2(NUM_ERR);
  localparam int ERR_POS [NUM_ERR] = '{1, 2, 3, 5};

  localparam int DESC_WORDS   = 5;
  localparam int IDX_W        = $clog2(DESC_WORDS);
  localparam int W_LINK       = 0;
  localparam int W_BCNT       = 3;
  localparam int W_DCTL       = 4;
  localparam int BCNT_W       = 25;
  localparam int DCTL_IRQ_BIT = 4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_MOVE} seq_state_e;
endpackage

// File: rtl/chdma_mover.sv
module chdma_mover #(
  parameter int XFER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic err_in,
  output logic done,
  output logic err
);
  localparam int CW = $clog2(XFER_CYCLES + 1);

  logic          active;
  logic [CW-1:0] cnt;

  assign done = active && (cnt == '0);
  assign err  = done && err_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(XFER_CYCLES - 1);
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/chdma_seq.sv
module chdma_seq
  import chdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              append,
  input  logic              enable,
  input  logic [AW-1:0]     nxt_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              busy,
  output logic [AW-1:0]     cur_addr,
  output logic [BCNT_W-1:0] bcnt,
  output logic [DW-1:0]     dctl,
  output logic              mem_req_valid,
  output logic [AW-1:0]     mem_req_addr,
  output logic              mv_start,
  output logic              ev_eot,
  output logic              ev_eoc,
  output logic              ev_err,
  output logic              irq,
  output logic              nxt_load,
  output logic [AW-1:0]     nxt_val
);
  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic             relink;
  logic [AW-1:0]    link_q;

  logic last_word, take_rsp, fin, clean, follow, go_start, go_relink;

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = cur_addr + AW'({idx, 2'b00});

  assign last_word = (idx == IDX_W'(DESC_WORDS - 1));
  assign take_rsp  = (st == S_WAIT) && mem_rsp_valid;
  assign mv_start  = take_rsp && !relink && last_word;

  assign fin    = (st == S_MOVE) && mv_done;
  assign ev_err = fin && mv_err;
  assign clean  = fin && !mv_err;
  assign ev_eot = clean;
  assign ev_eoc = clean && (link_q == '0);
  assign follow = clean && (link_q != '0) && enable;

  assign nxt_load = follow || (take_rsp && relink && (mem_rsp_data != '0));
  assign nxt_val  = follow ? link_q : mem_rsp_data;

  assign go_start  = (st == S_IDLE) && (nxt_addr != '0) &&
                     (start || (append && (cur_addr == '0)));
  assign go_relink = (st == S_IDLE) && append && !start && (cur_addr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      relink   <= 1'b0;
      cur_addr <= '0;
      link_q   <= '0;
      bcnt     <= '0;
      dctl     <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= clean && dctl[DCTL_IRQ_BIT];
      case (st)
        S_IDLE: begin
          if (go_start) begin
            cur_addr <= nxt_addr;
            idx      <= '0;
            relink   <= 1'b0;
            st       <= S_REQ;
          end else if (go_relink) begin
            idx    <= IDX_W'(W_LINK);
            relink <= 1'b1;
            st     <= S_REQ;
          end
        end
        S_REQ: begin
          if (mem_req_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (relink) begin
              relink <= 1'b0;
              if (mem_rsp_data != '0) begin
                cur_addr <= mem_rsp_data;
                idx      <= '0;
                st       <= S_REQ;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (idx == IDX_W'(W_LINK)) link_q <= mem_rsp_data;
              if (idx == IDX_W'(W_BCNT)) bcnt   <= mem_rsp_data[BCNT_W-1:0];
              if (idx == IDX_W'(W_DCTL)) dctl   <= mem_rsp_data;
              if (last_word) begin
                st <= S_MOVE;
              end else begin
                idx <= idx + 1'b1;
                st  <= S_REQ;
              end
            end
          end
        end
        S_MOVE: begin
          if (mv_done) begin
            if (follow) begin
              cur_addr <= link_q;
              idx      <= '0;
              st       <= S_REQ;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chdma_regs.sv
module chdma_regs
  import chdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic [AW-1:0]     cur_addr,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [DW-1:0]     dctl,
  input  logic              ev_eot,
  input  logic              ev_eoc,
  input  logic              ev_err,
  input  logic [KIND_W-1:0] err_kind,
  input  logic              nxt_load,
  input  logic [AW-1:0]     nxt_val,
  output logic [DW-1:0]     rdata,
  output logic              enable,
  output logic              start,
  output logic              append,
  output logic [AW-1:0]     nxt_addr,
  output logic              eot_flag,
  output logic              eoc_flag,
  output logic [NUM_ERR-1:0] err_flags
);
  logic          ctrl_wr, stat_wr;
  logic [DW-1:0] stat_word;

  assign ctrl_wr = wr && (addr == OFS_CTRL);
  assign stat_wr = wr && (addr == OFS_STAT);
  assign start   = ctrl_wr && wdata[0] && !enable && !busy;
  assign append  = ctrl_wr && wdata[0] && wdata[1] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      nxt_addr <= '0;
      eot_flag <= 1'b0;
      eoc_flag <= 1'b0;
    end else begin
      if (ctrl_wr) enable <= wdata[0];
      if (nxt_load) nxt_addr <= nxt_val;
      else if (wr && (addr == OFS_NEXT) && !busy) nxt_addr <= wdata;
      if (ev_eot) eot_flag <= 1'b1;
      else if (stat_wr && wdata[BIT_EOT]) eot_flag <= 1'b0;
      if (ev_eoc) eoc_flag <= 1'b1;
      else if (stat_wr && wdata[BIT_EOC]) eoc_flag <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n) err_flags[k] <= 1'b0;
      else if (ev_err && (err_kind == KIND_W'(k))) err_flags[k] <= 1'b1;
      else if (stat_wr && wdata[ERR_POS[k]]) err_flags[k] <= 1'b0;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_BUSY] = busy;
    stat_word[BIT_EOT]  = eot_flag;
    stat_word[BIT_EOC]  = eoc_flag;
    for (int k = 0; k < NUM_ERR; k++) stat_word[ERR_POS[k]] = err_flags[k];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata[0] = enable;
      OFS_STAT: rdata = stat_word;
      OFS_CUR:  rdata = cur_addr;
      OFS_NEXT: rdata = nxt_addr;
      OFS_BCNT: rdata[BCNT_W-1:0] = bcnt;
      OFS_DCTL: rdata = dctl;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/chdma_channel.sv
module chdma_channel
  import chdma_pkg::*;
#(
  parameter int XFER_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              err_inject,
  input  logic [KIND_W-1:0] err_kind,
  output logic              irq
);
  logic               busy, enable, start, append;
  logic [AW-1:0]      cur_addr, nxt_addr, nxt_val;
  logic [BCNT_W-1:0]  bcnt;
  logic [DW-1:0]      dctl;
  logic               ev_eot, ev_eoc, ev_err, nxt_load;
  logic               mv_start, mv_done, mv_err;
  logic               eot_flag, eoc_flag;
  logic [NUM_ERR-1:0] err_flags;

  chdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .cur_addr(cur_addr), .bcnt(bcnt), .dctl(dctl),
    .ev_eot(ev_eot), .ev_eoc(ev_eoc), .ev_err(ev_err), .err_kind(err_kind),
    .nxt_load(nxt_load), .nxt_val(nxt_val), .rdata(reg_rdata),
    .enable(enable), .start(start), .append(append), .nxt_addr(nxt_addr),
    .eot_flag(eot_flag), .eoc_flag(eoc_flag), .err_flags(err_flags)
  );

  chdma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .append(append), .enable(enable),
    .nxt_addr(nxt_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mv_done(mv_done), .mv_err(mv_err), .busy(busy), .cur_addr(cur_addr),
    .bcnt(bcnt), .dctl(dctl), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mv_start(mv_start), .ev_eot(ev_eot),
    .ev_eoc(ev_eoc), .ev_err(ev_err), .irq(irq), .nxt_load(nxt_load),
    .nxt_val(nxt_val)
  );

  chdma_mover #(.XFER_CYCLES(XFER_CYCLES)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(mv_start), .err_in(err_inject),
    .done(mv_done), .err(mv_err)
  );
endmodule

// File: rtl/chdma_channel_chk.sv
module chdma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        enable,
  input logic        eot_flag,
  input logic        eoc_flag,
  input logic [3:0]  err_flags,
  input logic        irq,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> enable); // R2
  AST_EOC_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_flag) |-> !busy); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_IRQ_WITH_EOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eot_flag); // R6
  AST_ERR_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|err_flags) |-> !busy); // R9
endmodule

bind chdma_channel chdma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .enable(enable),
  .eot_flag(eot_flag), .eoc_flag(eoc_flag), .err_flags(err_flags),
  .irq(irq), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/chdma_channel_test.sv
`timescale 1ns/1ps
module chdma_channel_test;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_CUR = 6'h0C,
                         A_NEXT = 6'h10, A_BCNT = 6'h20, A_DCTL = 6'h24;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        err_inject = 1'b0;
  logic [1:0]  err_kind = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chdma_channel #(.XFER_CYCLES(3)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .err_inject(err_inject), .err_kind(err_kind), .irq(irq)
  );

  // memory model
  logic [31:0] mem [64];
  bit          ready_all = 1'b1;
  int          lat = 0;
  int          cyc = 0;
  logic        pend = 1'b0;
  int          lcnt = 0;
  logic [31:0] pdata = '0;
  logic [31:0] req_log [1024];
  int          req_n = 0;
  int          irq_cnt = 0;

  assign mem_req_ready = ready_all || cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pend) begin
      if (lcnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pdata;
        pend          <= 1'b0;
      end else begin
        lcnt <= lcnt - 1;
      end
    end else if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      lcnt  <= lat;
      pdata <= mem[mem_req_addr[7:2]];
      req_log[req_n % 1024] <= mem_req_addr;
      req_n <= req_n + 1;
    end
  end

  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      rd(A_STAT, s);
      if (!s[10]) begin ok = 1'b1; break; end
    end
    check("R3 busy drops", {31'd0, ok}, 32'd1);
  endtask

  function automatic int err_pos(input int k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  // descriptor i at 0x20*(i+1); even i request irq
  task automatic build_chain(input int len);
    for (int i = 0; i < len; i++) begin
      int w = (32 * (i + 1)) / 4;
      mem[w + 0] = (i < len - 1) ? 32'(32 * (i + 2)) : 32'd0;
      mem[w + 1] = 32'hA000 + 32'(i);
      mem[w + 2] = 32'hB000 + 32'(i);
      mem[w + 3] = 32'h100 * 32'(i + 1) + 32'(len);
      mem[w + 4] = ((i % 2) == 0 ? 32'h10 : 32'h0) | (32'(i) << 12);
    end
  endtask

  task automatic launch();
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0);
    wr(A_NEXT, 32'h20);
  endtask

  task automatic run_chain(input int len, input int lt, input bit ra);
    logic [31:0] v;
    int n0, i0;
    lat = lt; ready_all = ra;
    build_chain(len);
    launch();
    n0 = req_n; i0 = irq_cnt;
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v);
    check("R3 busy after start", {31'd0, v[10]}, 32'd1);
    wait_idle();
    check("R4 request count", 32'(req_n - n0), 32'(5 * len));
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 5; k++)
        check("R4 fetch address", req_log[(n0 + 5 * i + k) % 1024],
              32'(32 * (i + 1) + 4 * k));
    rd(A_STAT, v); check("R5 eot and eoc", v, 32'h300);
    rd(A_CUR, v);  check("R2 current descriptor", v, 32'(32 * len));
    rd(A_NEXT, v); check("R5 next tracks link", v, 32'(32 * len));
    rd(A_BCNT, v); check("R4 byte count", v, 32'h100 * 32'(len) + 32'(len));
    rd(A_DCTL, v); check("R4 descriptor control", v,
                         (((len - 1) % 2) == 0 ? 32'h10 : 32'h0) | (32'(len - 1) << 12));
    check("R6 irq count", 32'(irq_cnt - i0), 32'((len + 1) / 2));
  endtask

  initial begin
    logic [31:0] v;
    int n0, i0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    rd(A_STAT, v); check("R1 status reset", v, 0);
    rd(A_CUR, v);  check("R1 current reset", v, 0);
    rd(A_NEXT, v); check("R1 next reset", v, 0);
    rd(A_BCNT, v); check("R1 byte count reset", v, 0);
    rd(A_DCTL, v); check("R1 dctl reset", v, 0);
    check("R1 irq low", {31'd0, irq}, 0);
    check("R1 no request", {31'd0, mem_req_valid}, 0);

    // R2 next register read-write while idle
    wr(A_NEXT, 32'h1234); rd(A_NEXT, v); check("R2 next write idle", v, 32'h1234);

    // sweep chain length, latency and ready pattern
    for (int len = 1; len <= 4; len++)
      for (int lt = 0; lt <= 2; lt += 2)
        for (int ra = 0; ra <= 1; ra++)
          run_chain(len, lt, ra[0]);

    // R7 write-1-to-clear, write 0 no effect
    wr(A_STAT, 32'h0);       rd(A_STAT, v); check("R7 write zero keeps", v, 32'h300);
    wr(A_STAT, 32'h200);     rd(A_STAT, v); check("R7 clear eot only", v, 32'h100);
    wr(A_STAT, 32'h100);     rd(A_STAT, v); check("R7 clear eoc", v, 32'h0);

    // R4 byte count boundary
    lat = 1; ready_all = 1'b1;
    mem[8] = 0; mem[11] = 32'h0100_0000; mem[12] = 0;
    launch(); wr(A_CTRL, 1); wait_idle();
    rd(A_BCNT, v); check("R4 max byte count", v, 32'h0100_0000);
    mem[11] = 32'hFF00_0010;
    launch(); wr(A_CTRL, 1); wait_idle();
    rd(A_BCNT, v); check("R4 upper bits dropped", v, 32'h0100_0010);

    // R9 error kinds
    for (int k = 0; k < 4; k++) begin
      lat = 1; ready_all = 1'b1;
      build_chain(2);
      launch();
      n0 = req_n; i0 = irq_cnt;
      err_kind = 2'(k); err_inject = 1'b1;
      wr(A_CTRL, 1);
      wait_idle();
      err_inject = 1'b0;
      rd(A_STAT, v); check("R9 error flag", v, 32'h1 << err_pos(k));
      rd(A_CUR, v);  check("R9 link not followed", v, 32'h20);
      rd(A_NEXT, v); check("R9 next unchanged", v, 32'h20);
      check("R9 fetch count", 32'(req_n - n0), 5);
      check("R9 no irq", 32'(irq_cnt - i0), 0);
      wr(A_STAT, 32'h0);              rd(A_STAT, v); check("R7 error kept by zero", v, 32'h1 << err_pos(k));
      wr(A_STAT, 32'h1 << err_pos(k)); rd(A_STAT, v); check("R7 error cleared", v, 0);
    end

    // R10 enable cleared mid-chain, R2 next write while busy ignored
    lat = 3; ready_all = 1'b0;
    build_chain(3);
    launch();
    n0 = req_n;
    wr(A_CTRL, 1);
    wr(A_NEXT, 32'hE0);
    wr(A_CTRL, 0);
    wait_idle();
    rd(A_STAT, v); check("R10 eot without eoc", v, 32'h200);
    rd(A_CUR, v);  check("R10 stopped at first", v, 32'h20);
    rd(A_NEXT, v); check("R2 busy next write ignored", v, 32'h20);
    check("R10 fetch count", 32'(req_n - n0), 5);
    rd(A_CTRL, v); check("R11 ctrl reads disabled", v, 0);

    // R8 append with link still zero
    lat = 0; ready_all = 1'b1;
    run_chain(1, 0, 1'b1);
    wr(A_STAT, 32'hFFFF_FFFF);
    n0 = req_n;
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); check("R11 append bit reads zero", v, 32'h1);
    wait_idle();
    check("R8 single relink read", 32'(req_n - n0), 1);
    check("R8 relink address", req_log[n0 % 1024], 32'h20);
    rd(A_STAT, v); check("R8 flags untouched", v, 0);
    rd(A_CUR, v);  check("R8 current unchanged", v, 32'h20);

    // R8 append after link patched
    mem[16] = 0; mem[19] = 32'h777; mem[20] = 32'h10;
    mem[8] = 32'h40;
    n0 = req_n; i0 = irq_cnt;
    wr(A_CTRL, 32'h3);
    wait_idle();
    check("R8 relink then fetch", 32'(req_n - n0), 6);
    check("R8 relink first", req_log[n0 % 1024], 32'h20);
    check("R8 new descriptor", req_log[(n0 + 1) % 1024], 32'h40);
    rd(A_STAT, v); check("R8 chain done", v, 32'h300);
    rd(A_CUR, v);  check("R8 current moved", v, 32'h40);
    rd(A_NEXT, v); check("R8 next moved", v, 32'h40);
    rd(A_BCNT, v); check("R8 byte count", v, 32'h777);
    check("R6 irq after append", 32'(irq_cnt - i0), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule